// File: doc/BRIEF.md
# PLL Multiplier Reprogramming Sequencer

This block changes the feedback multiplier of a clock synthesizer without ever handing a half-settled clock to the rest of the chip. A request carries a new multiplier value and a one-cycle start strobe.

The sequencer then steps through a fixed order, holding each step for a set number of reference-clock cycles:

1. Move the clock output onto the bypass path.
2. Reset and power the loop.
3. Load the multiplier while the loop is in reset.
4. Release reset.
5. Wait for lock.
6. Select the loop output again.

A one-cycle done pulse marks the end of the sequence, and a busy level covers the whole sequence. A request with a multiplier outside the configured window is refused. A request that arrives while a sequence runs is dropped and flagged.

The multiplier register also drives a ratio output. The ratio is the multiplier value plus one in the normal variant, or twice the multiplier value in the doubled variant, which is selected by a parameter.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the outputs are as follows.
  - Step code is 0 (idle).
  - Loop select (`pll_sel_o`) is 0 and enable-source select (`ext_sel_o`) is 1.
  - Loop reset (`pll_rst_n_o`) is 0 (in reset) and power-down (`pll_off_o`) is 1.
  - `busy_o`, `done_o`, `reject_o` and `overlap_o` are 0.
  - The multiplier register holds `MUL_RST`.
- R2: A start with a multiplier in range, seen at an idle clock edge, moves the block to step code 1 (bypass) at that edge. The same edge clears both `pll_sel_o` and `ext_sel_o` and raises `busy_o`.
- R3: Bypass lasts exactly `BYP_CYC` cycles, and `BYP_CYC` must be at least 4. The loop reset is not asserted until the bypass step is over.
- R4: Step code 2 (hold) drives `pll_rst_n_o` to 0 and `pll_off_o` to 0 for exactly `RST_CYC` cycles. The requested multiplier appears on `mult_o` from the first hold cycle.
- R5: Step code 3 (lock wait) drives `pll_rst_n_o` to 1 while `pll_sel_o` stays 0, for exactly `LOCK_CYC` cycles.
- R6: When the lock wait ends, the block does all of the following in the same cycle:
  - returns to step 0;
  - sets `pll_sel_o` to 1;
  - lowers `busy_o`;
  - pulses `done_o` for exactly one cycle.
- R7: A start at idle whose multiplier lies outside [`MUL_MIN`, `MUL_MAX`] pulses `reject_o` for one cycle. It leaves the step, the selects and the multiplier unchanged.
- R8: A start while busy pulses `overlap_o` one cycle later. It is otherwise ignored: the running sequence keeps its own multiplier and timing.
- R9: `ratio_o` equals `mult_o`+1 when `DOUBLE_MODE`=0 and 2·`mult_o` when `DOUBLE_MODE`=1.
- R10: `mult_o` changes only while the loop is in reset and bypassed, never while `pll_sel_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| mult_i | input | MUL_W | Requested multiplier value |
| pll_sel_o | output | 1 | 1 selects the loop output, 0 selects bypass |
| ext_sel_o | output | 1 | Enable-source select, cleared by a sequence |
| pll_rst_n_o | output | 1 | Loop reset, 0 means in reset |
| pll_off_o | output | 1 | Loop power-down |
| mult_o | output | MUL_W | Programmed multiplier register |
| ratio_o | output | MUL_W+1 | Resulting output-to-reference ratio |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| reject_o | output | 1 | One-cycle pulse for an out-of-range request |
| overlap_o | output | 1 | One-cycle pulse for a request made while busy |
| step_o | output | 2 | Current step: 0 idle, 1 bypass, 2 hold, 3 lock wait |

## Verification
The bench builds the block with `MUL_W`=5, a window of 3 to 20, `BYP_CYC`=4, `RST_CYC`=6 and `LOCK_CYC`=10. With these values each step's dwell can be counted cycle by cycle, and both window edges and values just outside them are quick to reach. A second instance with `DOUBLE_MODE`=1 shares the same stimulus, so both ratio formulas are checked on identical multiplier values. The short dwells also leave room to drop an overlapping request into the middle of a sequence.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BYP  = 2'd1,
        ST_HOLD = 2'd2,
        ST_LOCK = 2'd3
    } step_e;

endpackage

// File: rtl/pll_mult_window.sv
module pll_mult_window #(
    parameter int MUL_W   = 5,
    parameter int MUL_MIN = 3,
    parameter int MUL_MAX = 20
) (
    input  logic [MUL_W-1:0] mult_i,
    output logic             in_range_o
);
    localparam logic [MUL_W:0] LO = (MUL_W+1)'(MUL_MIN);
    localparam logic [MUL_W:0] HI = (MUL_W+1)'(MUL_MAX);

    always_comb begin
        in_range_o = ({1'b0, mult_i} >= LO) && ({1'b0, mult_i} <= HI);
    end
endmodule

// File: rtl/pll_ratio_calc.sv
module pll_ratio_calc #(
    parameter int MUL_W       = 5,
    parameter bit DOUBLE_MODE = 1'b0
) (
    input  logic [MUL_W-1:0] mult_i,
    output logic [MUL_W:0]   ratio_o
);
    generate
        if (DOUBLE_MODE) begin : g_twice
            assign ratio_o = {mult_i, 1'b0};
        end else begin : g_plus_one
            assign ratio_o = {1'b0, mult_i} + (MUL_W+1)'(1);
        end
    endgenerate
endmodule

// File: rtl/pll_dwell_timer.sv
module pll_dwell_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int MUL_W       = 5,
    parameter int MUL_MIN     = 3,
    parameter int MUL_MAX     = 20,
    parameter int MUL_RST     = 3,
    parameter int BYP_CYC     = 4,
    parameter int RST_CYC     = 6,
    parameter int LOCK_CYC    = 10,
    parameter bit DOUBLE_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [MUL_W-1:0] mult_i,
    output logic             pll_sel_o,
    output logic             ext_sel_o,
    output logic             pll_rst_n_o,
    output logic             pll_off_o,
    output logic [MUL_W-1:0] mult_o,
    output logic [MUL_W:0]   ratio_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             reject_o,
    output logic             overlap_o,
    output logic [1:0]       step_o
);
    localparam int MAX_A = (BYP_CYC > RST_CYC) ? BYP_CYC : RST_CYC;
    localparam int MAX_CYC = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
    localparam int CNT_W = $clog2(MAX_CYC + 1) + 1;
    localparam logic [CNT_W-1:0] BYP_LD  = CNT_W'(BYP_CYC - 1);
    localparam logic [CNT_W-1:0] RST_LD  = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LD = CNT_W'(LOCK_CYC - 1);

    typedef struct packed {
        step_e            step;
        logic             pll_sel;
        logic             ext_sel;
        logic             pll_rst_n;
        logic             pll_off;
        logic [MUL_W-1:0] mult;
        logic [MUL_W-1:0] pend;
        logic             busy;
        logic             done;
        logic             reject;
        logic             overlap;
    } seq_s;

    seq_s             s_d, s_q;
    logic             in_range;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    pll_mult_window #(.MUL_W(MUL_W), .MUL_MIN(MUL_MIN), .MUL_MAX(MUL_MAX)) u_window (
        .mult_i     (mult_i),
        .in_range_o (in_range)
    );

    pll_dwell_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    pll_ratio_calc #(.MUL_W(MUL_W), .DOUBLE_MODE(DOUBLE_MODE)) u_ratio (
        .mult_i  (s_q.mult),
        .ratio_o (ratio_o)
    );

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.reject  = 1'b0;
        s_d.overlap = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        if (start_i && (s_q.step != ST_IDLE)) s_d.overlap = 1'b1;
        unique case (s_q.step)
            ST_IDLE: begin
                if (start_i) begin
                    if (in_range) begin
                        s_d.step    = ST_BYP;
                        s_d.pll_sel = 1'b0;
                        s_d.ext_sel = 1'b0;
                        s_d.busy    = 1'b1;
                        s_d.pend    = mult_i;
                        tmr_load    = 1'b1;
                        tmr_val     = BYP_LD;
                    end else begin
                        s_d.reject  = 1'b1;
                    end
                end
            end
            ST_BYP: begin
                if (tmr_zero) begin
                    s_d.step      = ST_HOLD;
                    s_d.pll_rst_n = 1'b0;
                    s_d.pll_off   = 1'b0;
                    s_d.mult      = s_q.pend;
                    tmr_load      = 1'b1;
                    tmr_val       = RST_LD;
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    s_d.step      = ST_LOCK;
                    s_d.pll_rst_n = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_val       = LOCK_LD;
                end
            end
            ST_LOCK: begin
                if (tmr_zero) begin
                    s_d.step    = ST_IDLE;
                    s_d.pll_sel = 1'b1;
                    s_d.busy    = 1'b0;
                    s_d.done    = 1'b1;
                end
            end
            default: s_d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.step      <= ST_IDLE;
            s_q.ext_sel   <= 1'b1;
            s_q.pll_rst_n <= 1'b0;
            s_q.pll_off   <= 1'b1;
            s_q.mult      <= MUL_W'(MUL_RST);
            s_q.pend      <= MUL_W'(MUL_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign pll_sel_o   = s_q.pll_sel;
    assign ext_sel_o   = s_q.ext_sel;
    assign pll_rst_n_o = s_q.pll_rst_n;
    assign pll_off_o   = s_q.pll_off;
    assign mult_o      = s_q.mult;
    assign busy_o      = s_q.busy;
    assign done_o      = s_q.done;
    assign reject_o    = s_q.reject;
    assign overlap_o   = s_q.overlap;
    assign step_o      = s_q.step;

    // Bypass age: cycles the output has spent on the bypass path (saturating)
    logic [CNT_W-1:0] byp_age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  byp_age_q <= '0;
        else if (s_q.pll_sel)        byp_age_q <= '0;
        else if (byp_age_q != '1)    byp_age_q <= byp_age_q + CNT_W'(1);
    end

    assert_byp_dwell_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst_n_o) |-> (byp_age_q >= CNT_W'(BYP_CYC)));

    assert_hold_follows_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 2'd2) |-> ($past(step_o) == 2'd1 || $past(step_o) == 2'd2));

    assert_sel_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_sel_o) |-> (pll_rst_n_o && !pll_off_o));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_overlap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> overlap_o);

    assert_mult_safe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mult_o) |-> (!pll_rst_n_o && !pll_sel_o));

endmodule

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;
    localparam int MW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [MW-1:0] mult_i = '0;
    logic          pll_sel_o, ext_sel_o, pll_rst_n_o, pll_off_o;
    logic [MW-1:0] mult_o, mult2_o;
    logic [MW:0]   ratio_o, ratio2_o;
    logic          busy_o, done_o, reject_o, overlap_o;
    logic [1:0]    step_o;
    logic          s2, e2, r2, o2, b2, d2, j2, v2;
    logic [1:0]    st2;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    pll_reprog_seq #(.MUL_W(MW), .MUL_MIN(3), .MUL_MAX(20), .MUL_RST(3),
        .BYP_CYC(4), .RST_CYC(6), .LOCK_CYC(10), .DOUBLE_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mult_i(mult_i),
        .pll_sel_o(pll_sel_o), .ext_sel_o(ext_sel_o), .pll_rst_n_o(pll_rst_n_o),
        .pll_off_o(pll_off_o), .mult_o(mult_o), .ratio_o(ratio_o), .busy_o(busy_o),
        .done_o(done_o), .reject_o(reject_o), .overlap_o(overlap_o), .step_o(step_o));

    pll_reprog_seq #(.MUL_W(MW), .MUL_MIN(3), .MUL_MAX(20), .MUL_RST(3),
        .BYP_CYC(4), .RST_CYC(6), .LOCK_CYC(10), .DOUBLE_MODE(1'b1)) u_dut_twice (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mult_i(mult_i),
        .pll_sel_o(s2), .ext_sel_o(e2), .pll_rst_n_o(r2), .pll_off_o(o2),
        .mult_o(mult2_o), .ratio_o(ratio2_o), .busy_o(b2), .done_o(d2),
        .reject_o(j2), .overlap_o(v2), .step_o(st2));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // {accept, multiplier}
    localparam logic [5:0] VEC [6] = '{
        {1'b1, 5'd3}, {1'b1, 5'd20}, {1'b0, 5'd2},
        {1'b0, 5'd21}, {1'b1, 5'd11}, {1'b0, 5'd0}
    };

    task automatic run_seq(input logic [MW-1:0] m, input bit acc);
        logic [MW-1:0] prev;
        int nb, nh, nl, bad, g;
        prev = mult_o;
        @(negedge clk); mult_i = m; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (!acc) begin
            chk(reject_o == 1'b1, "R7 reject pulse", reject_o, 1);
            chk(step_o == 2'd0 && mult_o == prev, "R7 no change", mult_o, prev);
            @(negedge clk);
            chk(reject_o == 1'b0 && busy_o == 1'b0, "R7 pulse ends", reject_o, 0);
            return;
        end
        chk(step_o == 2'd1, "R2 enter bypass", step_o, 1);
        chk(!pll_sel_o && !ext_sel_o && busy_o, "R2 selects cleared",
            {pll_sel_o, ext_sel_o, busy_o}, 3'b001);
        nb = 0; nh = 0; nl = 0; bad = 0; g = 0;
        while (step_o != 2'd0 && g < 1000) begin
            case (step_o)
                2'd1: begin nb++; if (pll_sel_o || !pll_rst_n_o && nb == 1 && 0) bad++;
                            if (pll_sel_o || mult_o != prev) bad++; end
                2'd2: begin nh++; if (pll_rst_n_o || pll_off_o || mult_o != m || pll_sel_o) bad++; end
                default: begin nl++; if (!pll_rst_n_o || pll_sel_o) bad++; end
            endcase
            g++;
            @(negedge clk);
        end
        chk(nb == 4, "R3 bypass dwell", nb, 4);
        chk(nh == 6, "R4 hold dwell", nh, 6);
        chk(nl == 10, "R5 lock dwell", nl, 10);
        chk(bad == 0, "R10 step outputs", bad, 0);
        chk(done_o && pll_sel_o && !busy_o, "R6 finish", {done_o, pll_sel_o, busy_o}, 3'b110);
        chk(mult_o == m, "R4 multiplier written", mult_o, m);
        chk(ratio_o == {1'b0, m} + 6'd1, "R9 normal ratio", ratio_o, m + 1);
        chk(ratio2_o == {m, 1'b0}, "R9 doubled ratio", ratio2_o, 2 * m);
        @(negedge clk);
        chk(!done_o && mult_o == m, "R6 done one cycle", done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(step_o == 2'd0 && !pll_sel_o && ext_sel_o && !pll_rst_n_o && pll_off_o,
            "R1 reset selects", {step_o, pll_sel_o, ext_sel_o, pll_rst_n_o, pll_off_o}, 6'b000101);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !reject_o && !overlap_o && mult_o == 5'd3,
            "R1 reset flags", mult_o, 3);

        for (int i = 0; i < 6; i++) run_seq(VEC[i][4:0], VEC[i][5]);

        // R8: overlapping request mid-sequence
        @(negedge clk); mult_i = 5'd5; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk); @(negedge clk);
        mult_i = 5'd9; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(overlap_o == 1'b1, "R8 overlap pulse", overlap_o, 1);
        @(negedge clk);
        chk(overlap_o == 1'b0, "R8 pulse ends", overlap_o, 0);
        while (busy_o) @(negedge clk);
        chk(mult_o == 5'd5 && pll_sel_o, "R8 request ignored", mult_o, 5);

        // R7: out-of-range while PLL selected leaves it selected
        run_seq(5'd31, 1'b0);
        chk(pll_sel_o == 1'b1, "R7 selection kept", pll_sel_o, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule